// File: doc/BRIEF.md
# Multi-Source XOR Accumulation Engine

The engine combines four source regions of memory into one result region with a bitwise XOR. It works through the regions one buffer at a time and keeps the running result in an internal accumulator queue of 64-bit slots. A descriptor starts each operation. The descriptor holds four source base addresses, a destination base address, a byte count, a buffer-size select and a destination-write enable. For each buffer, the engine fetches the first source straight into the queue. It then folds each later source into the queue, one 8-byte beat at a time. If writing is enabled, it streams the queue out to the destination.

The memory side has two channels. The read channel takes an address with a request/ready handshake and returns data later with a valid strobe. Only one read is in flight at any time. The write channel carries address and data together under a request/ready handshake. The engine can leave a single buffer's result in the queue without writing it. This lets a later stage of the chip reuse the accumulator. The engine has these states:

- `ST_IDLE` waits for `start`.
- `ST_RD_REQ` issues a read.
- `ST_RD_WAIT` waits for read data and updates the queue slot.
- `ST_WR_REQ` streams the queue to the destination.
- `ST_NEXT_BUF` advances the addresses and the remaining count.
- `ST_FINISH` raises `done` for one cycle.

The transitions are:

| From | To | Condition |
|------|----|-----------|
| `ST_IDLE` | `ST_RD_REQ` | start with a non-zero count |
| `ST_IDLE` | `ST_FINISH` | start with a zero count |
| `ST_RD_REQ` | `ST_RD_WAIT` | the read is accepted |
| `ST_RD_WAIT` | `ST_RD_REQ` | more beats or sources remain |
| `ST_RD_WAIT` | `ST_WR_REQ` | last beat of the last source, write enabled |
| `ST_RD_WAIT` | `ST_FINISH` | last beat of the last source, write disabled |
| `ST_WR_REQ` | `ST_NEXT_BUF` | the last beat is written |
| `ST_NEXT_BUF` | `ST_RD_REQ` | bytes remain |
| `ST_NEXT_BUF` | `ST_FINISH` | no bytes remain |
| `ST_FINISH` | `ST_IDLE` | always |

Top module: `xor_accum_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req` and `wr_req` are all low, and no request is raised while the engine is not busy.
- R2: A buffer holds 1024 bytes (128 beats) when `small_buf` is 0, and 512 bytes (64 beats) when it is 1. After each buffer, every source address and the destination address advance by the full buffer size.
- R3: Within a buffer, the beats of source 0 are read at `src0 + offset + 8*k` for k counting up from 0, and are loaded into the queue unchanged.
- R4: Sources are read strictly in the order 0, 1, 2, 3. Each source covers every beat of the buffer before the next source starts. Each request keeps its address stable until it is accepted, and read and write requests are never raised together.
- R5: Each written beat equals the XOR of the four source beats at the same offset within the buffer.
- R6: With `dst_wr_en` = 1, the beats of each finished buffer are written to `dst + offset + 8*k` in ascending order, before any read of the next buffer. The data and address stay stable while the write is not accepted.
- R7: When the byte count exceeds one buffer, buffers are processed until the count is used up. The last buffer covers only the leftover bytes divided by 8 beats.
- R8: With `dst_wr_en` = 0, no write is issued. Only the first buffer (the byte count capped at the buffer size) is read, and the operation then finishes.
- R9: A zero byte count raises `done` in the cycle after `start` is taken, with no read or write request.
- R10: `busy` is high from the cycle after `start` until `done`. `done` is a single-cycle pulse during which `busy` is low.
- R11: A `start` pulse while the engine is busy is ignored and does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation with the descriptor fields below |
| src_addr_flat | input | 128 | Four source base addresses; source i sits at bits [32i+31:32i] |
| dst_addr | input | 32 | Destination base address |
| byte_cnt | input | 24 | Total bytes to process, a multiple of 8 |
| small_buf | input | 1 | 1 selects 512-byte buffers, 0 selects 1024-byte buffers |
| dst_wr_en | input | 1 | 1 writes results to memory, 0 keeps one buffer in the queue |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read address (8-byte beat) |
| rd_rdy | input | 1 | Read request accepted |
| rd_vld | input | 1 | Read data valid |
| rd_data | input | 64 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write address (8-byte beat) |
| wr_data | output | 64 | Write data |
| wr_rdy | input | 1 | Write accepted |

## Verification
The assertions take several things for granted about the inputs:

- Base addresses are 8-byte aligned, and byte counts are multiples of 8.
- `rd_vld` arrives only after a read has been accepted, with exactly one beat returned for each accepted read.
- `start` is sampled only while the engine is idle when a new operation is intended.

The stimulus keeps within these limits in three ways. It builds descriptors from aligned bases and counts in multiples of 8. Its memory responder returns data only for an accepted read, after a pseudo-random delay, while the ready lines toggle pseudo-randomly. The only `start` pulse raised mid-operation exists to show that such a pulse is ignored.

// File: rtl/xae_pkg.sv
package xae_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_NEXT_BUF,
        ST_FINISH
    } xae_state_e;

    localparam int BEAT_BYTES = 8;
    localparam int BEAT_SHIFT = 3;

endpackage

// File: rtl/xae_acc_queue.sv
// Accumulator store: one read-modify-write slot per 8-byte beat.
module xae_acc_queue #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic              load_raw,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [DATA_W-1:0] next_val;

    assign dout = slots[idx];

    // First source overwrites; later sources fold in by XOR.
    always_comb begin
        if (load_raw) next_val = din;
        else          next_val = slots[idx] ^ din;
    end

    always_ff @(posedge clk) begin
        if (wr_en) slots[idx] <= next_val;
    end

endmodule

// File: rtl/xae_buf_track.sv
// Remaining-count and buffer-offset bookkeeping.
module xae_buf_track #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    parameter int BIG_BYTES   = 1024,
    parameter int SMALL_BYTES = 512,
    localparam int IDX_W      = $clog2(BIG_BYTES / xae_pkg::BEAT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              small_in,
    input  logic              advance,
    output logic [IDX_W-1:0]  last_idx,
    output logic              more,
    output logic [ADDR_W-1:0] offset
);

    localparam logic [CNT_W-1:0] BIG_C   = CNT_W'(BIG_BYTES);
    localparam logic [CNT_W-1:0] SMALL_C = CNT_W'(SMALL_BYTES);

    logic [CNT_W-1:0] remaining;
    logic             small_q;
    logic [CNT_W-1:0] buf_bytes;
    logic [CNT_W-1:0] cur_bytes;
    logic [CNT_W-1:0] cur_beats_m1;

    assign buf_bytes    = small_q ? SMALL_C : BIG_C;
    assign cur_bytes    = (remaining < buf_bytes) ? remaining : buf_bytes;
    assign cur_beats_m1 = (cur_bytes >> xae_pkg::BEAT_SHIFT) - CNT_W'(1);
    assign last_idx     = cur_beats_m1[IDX_W-1:0];
    assign more         = remaining > buf_bytes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
            small_q   <= 1'b0;
            offset    <= '0;
        end else if (load) begin
            remaining <= cnt_in;
            small_q   <= small_in;
            offset    <= '0;
        end else if (advance) begin
            remaining <= remaining - cur_bytes;
            offset    <= offset + ADDR_W'(buf_bytes);
        end
    end

endmodule

// File: rtl/xor_accum_engine.sv
module xor_accum_engine #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    parameter int DATA_W      = 64,
    parameter int NUM_SRC     = 4,
    parameter int BIG_BYTES   = 1024,
    parameter int SMALL_BYTES = 512
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NUM_SRC*ADDR_W-1:0] src_addr_flat,
    input  logic [ADDR_W-1:0]         dst_addr,
    input  logic [CNT_W-1:0]          byte_cnt,
    input  logic                      small_buf,
    input  logic                      dst_wr_en,
    output logic                      busy,
    output logic                      done,
    output logic                      rd_req,
    output logic [ADDR_W-1:0]         rd_addr,
    input  logic                      rd_rdy,
    input  logic                      rd_vld,
    input  logic [DATA_W-1:0]         rd_data,
    output logic                      wr_req,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [DATA_W-1:0]         wr_data,
    input  logic                      wr_rdy
);
    import xae_pkg::*;

    localparam int DEPTH = BIG_BYTES / BEAT_BYTES;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [SRC_W-1:0] LAST_SRC = SRC_W'(NUM_SRC - 1);

    xae_state_e state, state_nx;

    logic [ADDR_W-1:0] src_base [NUM_SRC];
    logic [ADDR_W-1:0] dst_base;
    logic              wr_en_q;
    logic [SRC_W-1:0]  src_idx;
    logic [IDX_W-1:0]  beat;

    logic [IDX_W-1:0]  last_idx;
    logic              more;
    logic [ADDR_W-1:0] buf_off;
    logic [ADDR_W-1:0] beat_off;
    logic [DATA_W-1:0] q_dout;

    logic take_start, last_beat, last_src, rd_beat, wr_beat;

    assign take_start = (state == ST_IDLE) && start;
    assign last_beat  = (beat == last_idx);
    assign last_src   = (src_idx == LAST_SRC);
    assign rd_beat    = (state == ST_RD_WAIT) && rd_vld;
    assign wr_beat    = (state == ST_WR_REQ) && wr_rdy;
    assign beat_off   = ADDR_W'(beat) << BEAT_SHIFT;

    xae_buf_track #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .BIG_BYTES  (BIG_BYTES),
        .SMALL_BYTES(SMALL_BYTES)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_start),
        .cnt_in  (byte_cnt),
        .small_in(small_buf),
        .advance (state == ST_NEXT_BUF),
        .last_idx(last_idx),
        .more    (more),
        .offset  (buf_off)
    );

    xae_acc_queue #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_queue (
        .clk     (clk),
        .idx     (beat),
        .wr_en   (rd_beat),
        .load_raw(src_idx == '0),
        .din     (rd_data),
        .dout    (q_dout)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = (byte_cnt == '0) ? ST_FINISH : ST_RD_REQ;
            ST_RD_REQ:   if (rd_rdy) state_nx = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (rd_vld) begin
                    if (last_beat && last_src) state_nx = wr_en_q ? ST_WR_REQ : ST_FINISH;
                    else                       state_nx = ST_RD_REQ;
                end
            end
            ST_WR_REQ:   if (wr_rdy && last_beat) state_nx = ST_NEXT_BUF;
            ST_NEXT_BUF: state_nx = more ? ST_RD_REQ : ST_FINISH;
            ST_FINISH:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        rd_addr = src_base[src_idx] + buf_off + beat_off;
        wr_addr = dst_base + buf_off + beat_off;
        wr_data = q_dout;
        unique case (state)
            ST_IDLE:     ;
            ST_RD_REQ:   begin busy = 1'b1; rd_req = 1'b1; end
            ST_RD_WAIT:  busy = 1'b1;
            ST_WR_REQ:   begin busy = 1'b1; wr_req = 1'b1; end
            ST_NEXT_BUF: busy = 1'b1;
            ST_FINISH:   done = 1'b1;
            default:     ;
        endcase
    end

    // Descriptor latch and beat/source counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) src_base[i] <= '0;
            dst_base <= '0;
            wr_en_q  <= 1'b0;
            src_idx  <= '0;
            beat     <= '0;
        end else if (take_start) begin
            for (int i = 0; i < NUM_SRC; i++) src_base[i] <= src_addr_flat[i*ADDR_W +: ADDR_W];
            dst_base <= dst_addr;
            wr_en_q  <= dst_wr_en;
            src_idx  <= '0;
            beat     <= '0;
        end else if (rd_beat) begin
            if (last_beat) begin
                beat <= '0;
                if (!last_src) src_idx <= src_idx + SRC_W'(1);
            end else begin
                beat <= beat + IDX_W'(1);
            end
        end else if (wr_beat) begin
            beat <= last_beat ? '0 : beat + IDX_W'(1);
        end else if (state == ST_NEXT_BUF) begin
            src_idx <= '0;
            beat    <= '0;
        end
    end

endmodule

// File: rtl/xae_checker.sv
module xae_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  byte_cnt,
    input logic              busy,
    input logic              done,
    input logic              rd_req,
    input logic              rd_rdy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_req,
    input logic              wr_rdy,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);

    assert_no_req_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !wr_req));

    assert_rd_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[2:0] == 3'b000));

    assert_no_rw_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_rdy) |=> (rd_req && $stable(rd_addr)));

    assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_rdy) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_zero_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && byte_cnt == '0) |=> done);

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && byte_cnt != '0) |=> busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind xor_accum_engine xae_checker #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .byte_cnt(byte_cnt),
    .busy    (busy),
    .done    (done),
    .rd_req  (rd_req),
    .rd_rdy  (rd_rdy),
    .rd_addr (rd_addr),
    .wr_req  (wr_req),
    .wr_rdy  (wr_rdy),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
);

// File: tb/xor_accum_engine_tb.sv
module xor_accum_engine_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] src_addr_flat = '0;
    logic [31:0]  dst_addr = '0;
    logic [23:0]  byte_cnt = '0;
    logic         small_buf = 1'b0;
    logic         dst_wr_en = 1'b0;
    logic         busy, done, rd_req, wr_req;
    logic [31:0]  rd_addr, wr_addr;
    logic [63:0]  wr_data;
    logic         rd_rdy = 1'b0;
    logic         rd_vld = 1'b0;
    logic [63:0]  rd_data = '0;
    logic         wr_rdy = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    xor_accum_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr_flat(src_addr_flat),
        .dst_addr(dst_addr), .byte_cnt(byte_cnt), .small_buf(small_buf),
        .dst_wr_en(dst_wr_en), .busy(busy), .done(done),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_rdy(rd_rdy), .rd_vld(rd_vld),
        .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_rdy(wr_rdy)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_rd  = 0;
    int n_wr  = 0;

    logic [31:0] exp_rd [$];
    logic [95:0] exp_wr [$];

    logic [15:0] lfsr = 16'hACE1;
    int          rd_wait = -1;
    logic [31:0] rd_pend;

    function automatic logic [63:0] pat(input logic [31:0] a);
        return {a ^ 32'h1357_9BDF, (a << 1) ^ 32'h2468_ACE0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder and per-clock traffic comparison
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rd_vld) begin
            rd_vld = 1'b0;
        end else if (rd_wait > 0) begin
            rd_wait--;
        end else if (rd_wait == 0) begin
            rd_vld  = 1'b1;
            rd_data = pat(rd_pend);
            rd_wait = -1;
        end
        rd_rdy = lfsr[0] | lfsr[3];
        wr_rdy = lfsr[1] | lfsr[6];
        if (rst_n && rd_req && rd_rdy) begin
            n_rd++;
            if (exp_rd.size() == 0) begin
                check(1'b0, "R4/R8 unexpected read", {64'd0, rd_addr}, 96'd0);
            end else begin
                logic [31:0] e;
                e = exp_rd.pop_front();
                check(rd_addr == e, "R2/R3/R4/R7 read address", {64'd0, rd_addr}, {64'd0, e});
            end
            rd_pend = rd_addr;
            rd_wait = int'(lfsr[5:4]);
        end
        if (rst_n && wr_req && wr_rdy) begin
            n_wr++;
            if (exp_wr.size() == 0) begin
                check(1'b0, "R6/R8 unexpected write", {wr_addr, wr_data}, 96'd0);
            end else begin
                logic [95:0] e;
                e = exp_wr.pop_front();
                check({wr_addr, wr_data} == e, "R5/R6 write addr/data", {wr_addr, wr_data}, e);
            end
        end
    end

    task automatic run_op(input logic [31:0] s0, input logic [31:0] s1,
                          input logic [31:0] s2, input logic [31:0] s3,
                          input logic [31:0] d, input int cnt,
                          input bit sm, input bit dwe, input bit glitch);
        int bufsz, rem, off, beats, cyc, rd0, wr0;
        logic [31:0] s [4];
        s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
        bufsz = sm ? 512 : 1024;
        rem = cnt; off = 0;
        while (rem > 0) begin
            beats = ((rem < bufsz) ? rem : bufsz) / 8;
            for (int k = 0; k < 4; k++)
                for (int b = 0; b < beats; b++)
                    exp_rd.push_back(s[k] + 32'(off + 8*b));
            if (!dwe) break;
            for (int b = 0; b < beats; b++) begin
                logic [63:0] x;
                x = pat(s0 + 32'(off + 8*b)) ^ pat(s1 + 32'(off + 8*b)) ^
                    pat(s2 + 32'(off + 8*b)) ^ pat(s3 + 32'(off + 8*b));
                exp_wr.push_back({d + 32'(off + 8*b), x});
            end
            rem -= beats * 8;
            off += bufsz;
        end
        rd0 = n_rd; wr0 = n_wr;
        @(negedge clk);
        src_addr_flat = {s3, s2, s1, s0};
        dst_addr = d; byte_cnt = 24'(cnt); small_buf = sm; dst_wr_en = dwe;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done) begin
            check(busy == 1'b1, "R10 busy during operation", {95'd0, busy}, 96'd1);
            if (glitch && cyc == 60) begin
                // R11: a different descriptor pulsed mid-operation
                src_addr_flat = {4{32'h0F00_0000}};
                dst_addr = 32'h0E00_0000; byte_cnt = 24'd8; dst_wr_en = 1'b0;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (cyc > 40000) begin
                check(1'b0, "R10 watchdog expired", 96'(cyc), 96'd0);
                return;
            end
        end
        start = 1'b0;
        check(busy == 1'b0, "R10 busy low with done", {95'd0, busy}, 96'd0);
        if (cnt == 0) begin
            check(cyc == 1, "R9 zero count done latency", 96'(cyc), 96'd1);
            check(n_rd == rd0 && n_wr == wr0, "R9 no traffic on zero count",
                  96'(n_rd - rd0 + n_wr - wr0), 96'd0);
        end
        check(exp_rd.size() == 0, "R7/R8 all expected reads seen", 96'(exp_rd.size()), 96'd0);
        check(exp_wr.size() == 0, "R6/R7 all expected writes seen", 96'(exp_wr.size()), 96'd0);
        if (!dwe) check(n_wr == wr0, "R8 no writes when disabled", 96'(n_wr - wr0), 96'd0);
        if (glitch) check(exp_rd.size() == 0 && exp_wr.size() == 0,
                          "R11 mid-operation start ignored", 96'(exp_rd.size()), 96'd0);
        @(negedge clk);
        check(done == 1'b0, "R10 done single pulse", {95'd0, done}, 96'd0);
        exp_rd.delete();
        exp_wr.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle state after reset
        check({busy, done, rd_req, wr_req} == 4'b0, "R1 outputs in reset",
              96'({busy, done, rd_req, wr_req}), 96'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, rd_req, wr_req} == 4'b0, "R1 outputs after reset",
              96'({busy, done, rd_req, wr_req}), 96'd0);
        // R2/R3/R5/R6: one full 1024-byte buffer
        run_op(32'h0001_0000, 32'h0002_0000, 32'h0003_0000, 32'h0004_0000,
               32'h0008_0000, 1024, 1'b0, 1'b1, 1'b0);
        // R2/R7: 512-byte buffers with a short last buffer, plus R11 glitch
        run_op(32'h0010_0000, 32'h0020_0008, 32'h0030_0100, 32'h0040_0800,
               32'h0050_0000, 1536 + 256, 1'b1, 1'b1, 1'b1);
        // R7: short single transfer with big buffers
        run_op(32'h0100_0000, 32'h0100_4000, 32'h0100_8000, 32'h0100_C000,
               32'h0200_0000, 40, 1'b0, 1'b1, 1'b0);
        // R8: writes disabled, count above one buffer
        run_op(32'h0300_0000, 32'h0310_0000, 32'h0320_0000, 32'h0330_0000,
               32'h0340_0000, 2048, 1'b0, 1'b0, 1'b0);
        // R8: writes disabled, count under one buffer
        run_op(32'h0400_0000, 32'h0410_0000, 32'h0420_0000, 32'h0430_0000,
               32'h0440_0000, 200, 1'b1, 1'b0, 1'b0);
        // R9: zero count
        run_op(32'h0500_0000, 32'h0510_0000, 32'h0520_0000, 32'h0530_0000,
               32'h0540_0000, 0, 1'b0, 1'b1, 1'b0);
        // R2/R7: two full big buffers
        run_op(32'h0600_0000, 32'h0610_0000, 32'h0620_0000, 32'h0630_0000,
               32'h0640_0000, 2048, 1'b0, 1'b1, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule